// File: doc/BRIEF.md
# Receive Frame Page Formatter

This block takes one received Ethernet frame, presented as a byte stream with its length given up front, and lays it out in one page of packet RAM. The stored page has five parts: a 16-bit status word, a 16-bit byte count, the frame data (zero-padded to the minimum frame size when short), an optional CRC-32, and a closing word. The closing word holds the odd last byte of a long odd-length frame, followed by a control byte. The CRC is stored on a 16-bit boundary ahead of that odd byte.

The caller allocates the page and supplies its number with the start strobe. The caller also queues the page afterwards. The header is written last, once the page is complete, and a one-cycle completion pulse then acts as the receive interrupt. A frame that cannot be stored is still drained from the stream, so the source never stalls. Such a frame leaves the RAM untouched and raises no completion.

Top module: `rxfmt_top`

## Requirements
- R1: Page bytes 0 (low) and 1 (high) hold a status word. Bit 11 (byte 1 value 0x08) is set when the frame length exceeds 1518. Bit 12 (byte 1 value 0x10) is set when the length is odd. All other status bits are zero.
- R2: Page bytes 2 (low) and 3 (high) hold the byte count. It is computed from the frame length rounded down to even, or 64 when the frame is shorter than 64 bytes. That value plus 6 is the count, plus a further 4 when CRC storage is on. The count equals the number of page bytes written.
- R3: The even-length part of the frame is stored in arrival order from byte 4 upward.
- R4: A frame shorter than 64 bytes has its odd last byte stored directly after its even part. Zeros then fill the data area up to byte 67. From that point on, the frame counts as a 64-byte even frame.
- R5: When `cfg_keep_crc` is 1, a CRC-32 is stored LSB first directly after the data area. The CRC uses the reflected polynomial 0xEDB88320, starts from all ones and is inverted at the end. It covers every frame byte for frames of 64 bytes or more, and the 64 padded data bytes for shorter frames. When the input is 0, no CRC is stored.
- R6: The last two page bytes are the odd last byte then 0x60 for an odd frame of 64 bytes or more. For every other frame they are 0x00 then 0x40.
- R7: A frame is rejected when `cfg_rx_en` is 0, when `cfg_soft_rst` is 1, or when its byte count exceeds 2048. All of its bytes are still accepted on the input, but it writes nothing to RAM and raises no `done`.
- R8: Every write of a frame goes to the page given at its start. `done` is high for exactly one cycle, and that cycle is the one right after the frame's final RAM write.
- R9: A `frm_start` while `busy` is high is ignored, and the frame in progress completes unchanged.
- R10: During and right after reset, `busy`, `in_ready`, `ram_we` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rx_en | input | 1 | Receive enable, sampled at start |
| cfg_soft_rst | input | 1 | Soft reset, rejects the frame when high at start |
| cfg_keep_crc | input | 1 | Store CRC-32 after the data when 1 |
| frm_start | input | 1 | Starts a frame when idle |
| frm_len | input | LEN_W | Frame length in bytes, sampled with frm_start |
| frm_page | input | PAGE_W | Target page number, sampled with frm_start |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| ram_we | output | 1 | Packet RAM byte write enable |
| ram_page | output | PAGE_W | Page number of the write |
| ram_addr | output | ADDR_W | Byte address within the page |
| ram_wdata | output | 8 | Byte written |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle receive completion pulse |

## Verification
The bench builds the block with a 2048-byte page and a 12-bit length field. With those values, frame lengths up to 4095 can be requested, which reaches both sides of the byte-count rejection limit in each CRC mode. It also reaches the 1518-byte long-frame flag and all short, 64-byte and odd-length layouts. CRC storage is built in, so both values of the keep-CRC input are exercised, along with four pages for checking the write page.

// File: rtl/rxfmt_pkg.sv
package rxfmt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DATA,
      ST_DROP,
      ST_PAD,
      ST_CRC,
      ST_TAIL,
      ST_HDR
   } fmt_state_t;

   localparam logic [31:0] CRC_POLY = 32'hEDB88320;

   // One byte of reflected CRC-32, least significant bit first.
   function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] d);
      logic [31:0] c;
      c = c_in ^ {24'd0, d};
      for (int k = 0; k < 8; k++) begin
         c = {1'b0, c[31:1]} ^ (c[0] ? CRC_POLY : 32'd0);
      end
      return c;
   endfunction

endpackage

// File: rtl/rxfmt_crc.sv
module rxfmt_crc
   import rxfmt_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        en,
   input  logic [7:0]  din,
   output logic [31:0] crc_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= '1;
      end else if (clr) begin
         crc_q <= '1;
      end else if (en) begin
         crc_q <= crc_step(crc_q, din);
      end
   end

endmodule

// File: rtl/rxfmt_plan.sv
module rxfmt_plan #(
   parameter int LEN_W      = 12,
   parameter int CNT_W      = 13,
   parameter int PAGE_BYTES = 2048,
   parameter int MIN_FRAME  = 64,
   parameter int LONG_LIMIT = 1518
) (
   input  logic [LEN_W-1:0] len,
   input  logic             keep_crc,
   input  logic             rx_en,
   input  logic             soft_rst,
   output logic [CNT_W-1:0] count,
   output logic             odd,
   output logic             is_short,
   output logic             too_long,
   output logic             reject
);

   localparam int OVERHEAD = 6;
   localparam int CRC_LEN  = 4;

   logic [CNT_W-1:0] even_len;
   logic [CNT_W-1:0] base_len;

   always_comb begin
      even_len = CNT_W'({len[LEN_W-1:1], 1'b0});
      odd      = len[0];
      is_short = len < LEN_W'(MIN_FRAME);
      too_long = len > LEN_W'(LONG_LIMIT);
      base_len = is_short ? CNT_W'(MIN_FRAME) : even_len;
      count    = base_len + CNT_W'(OVERHEAD) + (keep_crc ? CNT_W'(CRC_LEN) : '0);
      reject   = !rx_en || soft_rst || (count > CNT_W'(PAGE_BYTES));
   end

endmodule

// File: rtl/rxfmt_top.sv
module rxfmt_top
   import rxfmt_pkg::*;
#(
   parameter int PAGE_BYTES = 2048,
   parameter int PAGE_W     = 2,
   parameter int LEN_W      = 12,
   parameter int MIN_FRAME  = 64,
   parameter int LONG_LIMIT = 1518,
   parameter bit CRC_EN     = 1'b1,
   localparam int ADDR_W    = $clog2(PAGE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_rx_en,
   input  logic              cfg_soft_rst,
   input  logic              cfg_keep_crc,
   input  logic              frm_start,
   input  logic [LEN_W-1:0]  frm_len,
   input  logic [PAGE_W-1:0] frm_page,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   output logic              in_ready,
   output logic              ram_we,
   output logic [PAGE_W-1:0] ram_page,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [7:0]        ram_wdata,
   output logic              busy,
   output logic              done
);

   localparam int PTR_W   = ADDR_W + 1;
   localparam int CNT_W   = LEN_W + 1;
   localparam int HDR_LEN = 4;
   localparam int PAD_END = HDR_LEN + MIN_FRAME;

   // Elaboration-time parameter checks.
   if (CNT_W > 16) begin : g_bad_len
      $error("rxfmt_top: LEN_W too wide for a 16-bit byte count");
   end
   if (PAGE_BYTES < PAD_END + 6 || PAGE_BYTES >= (1 << CNT_W)) begin : g_bad_page
      $error("rxfmt_top: PAGE_BYTES out of range for MIN_FRAME/LEN_W");
   end
   if ((1 << LEN_W) <= LONG_LIMIT || MIN_FRAME % 2 != 0) begin : g_bad_limits
      $error("rxfmt_top: LONG_LIMIT or MIN_FRAME invalid");
   end

   fmt_state_t        state;
   logic [PTR_W-1:0]  ptr;
   logic [LEN_W-1:0]  rem;
   logic [1:0]        sub;
   logic [PAGE_W-1:0] page_q;
   logic              keep_q, odd_q, short_q, long_q;
   logic [CNT_W-1:0]  count_q;
   logic [7:0]        hold_q;
   logic              done_q;

   logic              keep_eff;
   logic [31:0]       crc_q;
   logic              crc_clr, crc_en;
   logic [7:0]        crc_din;

   logic [CNT_W-1:0]  p_count;
   logic              p_odd, p_short, p_long, p_reject;

   logic              last_byte, hold_it, odd_long;
   logic [31:0]       crc_fin;
   logic [15:0]       cnt16;

   // CRC engine variant chosen by parameter.
   if (CRC_EN) begin : g_crc
      assign keep_eff = cfg_keep_crc;
      rxfmt_crc u_crc (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (crc_clr),
         .en    (crc_en),
         .din   (crc_din),
         .crc_q (crc_q)
      );
   end else begin : g_nocrc
      assign keep_eff = 1'b0;
      assign crc_q    = '0;
   end

   rxfmt_plan #(
      .LEN_W      (LEN_W),
      .CNT_W      (CNT_W),
      .PAGE_BYTES (PAGE_BYTES),
      .MIN_FRAME  (MIN_FRAME),
      .LONG_LIMIT (LONG_LIMIT)
   ) u_plan (
      .len      (frm_len),
      .keep_crc (keep_eff),
      .rx_en    (cfg_rx_en),
      .soft_rst (cfg_soft_rst),
      .count    (p_count),
      .odd      (p_odd),
      .is_short (p_short),
      .too_long (p_long),
      .reject   (p_reject)
   );

   assign last_byte = (rem == LEN_W'(1));
   assign odd_long  = odd_q && !short_q;
   assign hold_it   = (state == ST_DATA) && last_byte && odd_long;
   assign crc_clr   = (state == ST_IDLE);
   assign crc_en    = ((state == ST_DATA) && in_valid) || (state == ST_PAD);
   assign crc_din   = (state == ST_PAD) ? 8'h00 : in_data;
   assign crc_fin   = ~crc_q;
   assign cnt16     = 16'(count_q);

   assign busy     = (state != ST_IDLE);
   assign in_ready = (state == ST_DATA) || (state == ST_DROP);
   assign ram_page = page_q;
   assign done     = done_q;

   always_comb begin
      ram_we    = 1'b0;
      ram_addr  = ptr[ADDR_W-1:0];
      ram_wdata = 8'h00;
      unique case (state)
         ST_DATA: begin
            ram_we    = in_valid && !hold_it;
            ram_wdata = in_data;
         end
         ST_PAD: ram_we = 1'b1;
         ST_CRC: begin
            ram_we = 1'b1;
            unique case (sub)
               2'd0:    ram_wdata = crc_fin[7:0];
               2'd1:    ram_wdata = crc_fin[15:8];
               2'd2:    ram_wdata = crc_fin[23:16];
               default: ram_wdata = crc_fin[31:24];
            endcase
         end
         ST_TAIL: begin
            ram_we = 1'b1;
            if (sub[0]) ram_wdata = odd_long ? 8'h60 : 8'h40;
            else        ram_wdata = odd_long ? hold_q : 8'h00;
         end
         ST_HDR: begin
            ram_we   = 1'b1;
            ram_addr = ADDR_W'(sub);
            unique case (sub)
               2'd0:    ram_wdata = 8'h00;
               2'd1:    ram_wdata = {3'b000, odd_q, long_q, 3'b000};
               2'd2:    ram_wdata = cnt16[7:0];
               default: ram_wdata = cnt16[15:8];
            endcase
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         ptr     <= '0;
         rem     <= '0;
         sub     <= '0;
         page_q  <= '0;
         keep_q  <= 1'b0;
         odd_q   <= 1'b0;
         short_q <= 1'b0;
         long_q  <= 1'b0;
         count_q <= '0;
         hold_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: if (frm_start) begin
               rem     <= frm_len;
               ptr     <= PTR_W'(HDR_LEN);
               sub     <= '0;
               page_q  <= frm_page;
               keep_q  <= keep_eff;
               odd_q   <= p_odd;
               short_q <= p_short;
               long_q  <= p_long;
               count_q <= p_count;
               if (p_reject)
                  state <= (frm_len == '0) ? ST_IDLE : ST_DROP;
               else
                  state <= (frm_len == '0) ? ST_PAD : ST_DATA;
            end
            ST_DATA: if (in_valid) begin
               rem <= rem - LEN_W'(1);
               if (hold_it) hold_q <= in_data;
               else         ptr    <= ptr + PTR_W'(1);
               if (last_byte)
                  state <= short_q ? ST_PAD : (keep_q ? ST_CRC : ST_TAIL);
            end
            ST_DROP: if (in_valid) begin
               rem <= rem - LEN_W'(1);
               if (last_byte) state <= ST_IDLE;
            end
            ST_PAD: begin
               ptr <= ptr + PTR_W'(1);
               if (ptr == PTR_W'(PAD_END - 1))
                  state <= keep_q ? ST_CRC : ST_TAIL;
            end
            ST_CRC: begin
               ptr <= ptr + PTR_W'(1);
               sub <= sub + 2'd1;
               if (sub == 2'd3) state <= ST_TAIL;
            end
            ST_TAIL: begin
               ptr <= ptr + PTR_W'(1);
               sub <= (sub == 2'd1) ? 2'd0 : sub + 2'd1;
               if (sub == 2'd1) state <= ST_HDR;
            end
            ST_HDR: begin
               sub <= sub + 2'd1;
               if (sub == 2'd3) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/rxfmt_chk.sv
module rxfmt_chk #(
   parameter int PAGE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frm_start,
   input logic              busy,
   input logic              in_ready,
   input logic              ram_we,
   input logic [PAGE_W-1:0] ram_page,
   input logic              done
);

   a_r8_done_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(ram_we));

   a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r7_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ram_we);

   a_r10_ready_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> busy);

   a_r8_page_held: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && $past(ram_we)) |-> $stable(ram_page));

   a_r9_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && frm_start) |=> $stable(ram_page));

endmodule

bind rxfmt_top rxfmt_chk #(.PAGE_W(PAGE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .frm_start (frm_start),
   .busy      (busy),
   .in_ready  (in_ready),
   .ram_we    (ram_we),
   .ram_page  (ram_page),
   .done      (done)
);

// File: tb/sim_rxfmt_top.sv
`timescale 1ns/1ps
module sim_rxfmt_top;

   localparam int PAGE_BYTES = 2048;
   localparam int PAGE_W     = 2;
   localparam int LEN_W      = 12;
   localparam int ADDR_W     = 11;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_rx_en = 1'b0, cfg_soft_rst = 1'b0, cfg_keep_crc = 1'b0;
   logic              frm_start = 1'b0;
   logic [LEN_W-1:0]  frm_len = '0;
   logic [PAGE_W-1:0] frm_page = '0;
   logic              in_valid = 1'b0;
   logic [7:0]        in_data = '0;
   logic              in_ready, ram_we, busy, done;
   logic [PAGE_W-1:0] ram_page;
   logic [ADDR_W-1:0] ram_addr;
   logic [7:0]        ram_wdata;

   always #5 clk = ~clk;

   rxfmt_top #(.PAGE_BYTES(PAGE_BYTES), .PAGE_W(PAGE_W), .LEN_W(LEN_W)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_rx_en(cfg_rx_en), .cfg_soft_rst(cfg_soft_rst),
      .cfg_keep_crc(cfg_keep_crc), .frm_start(frm_start), .frm_len(frm_len),
      .frm_page(frm_page), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .ram_we(ram_we), .ram_page(ram_page), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .busy(busy), .done(done));

   int checks = 0, failures = 0;
   int cyc = 0;
   int frame_id = 0;
   int exp_page = 0;
   logic [7:0] mem   [PAGE_BYTES];
   int         stamp [PAGE_BYTES];
   int wr_n = 0, done_n = 0, page_bad = 0, last_wr = -10, done_cyc = -10;
   logic [7:0] fb  [4096];
   logic [7:0] ex  [PAGE_BYTES];

   always @(posedge clk) cyc <= cyc + 1;

   // Monitor, sampled away from the active edge.
   always @(negedge clk) begin
      if (ram_we) begin
         mem[ram_addr]   = ram_wdata;
         stamp[ram_addr] = frame_id;
         wr_n++;
         last_wr = cyc;
         if (int'(ram_page) != exp_page) page_bad++;
      end
      if (done) begin
         done_n++;
         done_cyc = cyc;
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   function automatic int ref_count(input int len, input bit keep);
      int base;
      base = (len < 64) ? 64 : (len / 2) * 2;
      return base + 6 + (keep ? 4 : 0);
   endfunction

   function automatic logic [31:0] ref_crc(input int lo, input int n);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < n; i++) begin
         for (int b = 0; b < 8; b++) begin
            if (c[0] ^ ex[lo + i][b]) c = (c >> 1) ^ 32'hEDB88320;
            else                      c = c >> 1;
         end
      end
      return ~c;
   endfunction

   task automatic compare_range(input int lo, input int hi, input string req, input string what);
      bit ok = 1;
      int bad_a = 0, act = 0, expv = 0;
      for (int a = lo; a < hi; a++) begin
         if (ok && (stamp[a] != frame_id || mem[a] !== ex[a])) begin
            ok = 0; bad_a = a; act = int'(mem[a]); expv = int'(ex[a]);
         end
      end
      chk(ok, req, $sformatf("%s frame %0d byte %0d", what, frame_id, bad_a), act, expv);
   endtask

   task automatic send_bytes(input int len);
      for (int i = 0; i < len; i++) begin
         if ($urandom % 4 == 0) begin @(posedge clk); #2; end
         in_valid = 1'b1;
         in_data  = fb[i];
         do @(negedge clk); while (!in_ready);
         @(posedge clk); #2;
         in_valid = 1'b0;
      end
   endtask

   task automatic run_frame(input int len, input bit keep, input bit rxen, input bit srst,
                            input int page, input bit poke);
      int cnt, wr0, dn0, pb0, even, dend, p;
      bit rej;
      logic [31:0] crc;
      frame_id++;
      for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
      cnt = ref_count(len, keep);
      rej = !rxen || srst || (cnt > PAGE_BYTES);
      while (busy) @(negedge clk);
      @(posedge clk); #2;
      exp_page = page;
      wr0 = wr_n; dn0 = done_n; pb0 = page_bad;
      cfg_rx_en = rxen; cfg_soft_rst = srst; cfg_keep_crc = keep;
      frm_len = LEN_W'(len); frm_page = PAGE_W'(page); frm_start = 1'b1;
      @(posedge clk); #2;
      frm_start = 1'b0;
      if (poke) begin
         // R9: second start while busy with another page and length
         frm_page = PAGE_W'(page + 2); frm_len = LEN_W'(5); frm_start = 1'b1;
         @(posedge clk); #2;
         frm_start = 1'b0;
      end
      send_bytes(len);
      for (int w = 0; w < 200 && busy; w++) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(!busy, "R8", "returns idle", int'(busy), 0);
      if (rej) begin
         chk(wr_n == wr0, "R7", $sformatf("writes for rejected len %0d", len), wr_n - wr0, 0);
         chk(done_n == dn0, "R7", "done for rejected frame", done_n - dn0, 0);
         return;
      end
      // Build expected page.
      even = (len / 2) * 2;
      for (int a = 0; a < PAGE_BYTES; a++) ex[a] = 8'h00;
      ex[1] = 8'(((len > 1518) ? 8 : 0) | ((len % 2) ? 16 : 0));
      ex[2] = 8'(cnt);
      ex[3] = 8'(cnt >> 8);
      for (int i = 0; i < even; i++) ex[4 + i] = fb[i];
      if (len < 64) begin
         if (len % 2) ex[4 + even] = fb[len - 1];
         dend = 68;
         crc = ref_crc(4, 64);
      end else begin
         dend = 4 + even;
         for (int i = 0; i < len; i++) ex[4 + i] = fb[i];
         crc = ref_crc(4, len);
      end
      p = dend;
      if (keep) begin
         for (int k = 0; k < 4; k++) ex[p + k] = crc[8*k +: 8];
         p += 4;
      end
      ex[p]     = (len >= 64 && len % 2) ? fb[len - 1] : 8'h00;
      ex[p + 1] = (len >= 64 && len % 2) ? 8'h60 : 8'h40;
      compare_range(0, 2, "R1", "status");
      compare_range(2, 4, "R2", "count");
      if (even > 0) compare_range(4, 4 + even, "R3", "data");
      if (len < 64) compare_range(4 + even, 68, "R4", "short pad");
      if (keep) compare_range(dend, dend + 4, "R5", "crc");
      compare_range(p, p + 2, "R6", "trailer");
      chk(wr_n - wr0 == cnt, "R2", $sformatf("bytes written len %0d", len), wr_n - wr0, cnt);
      chk(done_n - dn0 == 1, "R8", "done pulses", done_n - dn0, 1);
      chk(done_cyc == last_wr + 1, "R8", "done cycle after last write", done_cyc, last_wr + 1);
      chk(page_bad == pb0, poke ? "R9" : "R8", "write page", page_bad - pb0, 0);
   endtask

   initial begin
      int wd = 0;
      forever begin
         @(posedge clk);
         wd++;
         if (wd > 150000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int a = 0; a < PAGE_BYTES; a++) stamp[a] = 0;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(!busy && !in_ready && !ram_we && !done, "R10", "outputs in reset",
          int'({busy, in_ready, ram_we, done}), 0);
      @(posedge clk); #2; rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !in_ready && !ram_we && !done, "R10", "outputs after reset",
          int'({busy, in_ready, ram_we, done}), 0);

      // Directed corner cases.
      run_frame(1,    1, 1, 0, 0, 0);  // R4 odd short
      run_frame(62,   0, 1, 0, 1, 0);  // R4 even short, no CRC
      run_frame(63,   1, 1, 0, 2, 0);  // R4 one pad byte
      run_frame(64,   1, 1, 0, 3, 0);  // R3 exact minimum
      run_frame(65,   1, 1, 0, 0, 0);  // R6 odd long with CRC
      run_frame(65,   0, 1, 0, 1, 0);  // R6 odd long without CRC
      run_frame(1518, 1, 1, 0, 2, 0);  // R1 at long limit
      run_frame(1519, 0, 1, 0, 3, 0);  // R1 past long limit, odd
      run_frame(2039, 1, 1, 0, 0, 0);  // R2 count exactly 2048
      run_frame(2040, 1, 1, 0, 1, 0);  // R7 count 2050 rejected
      run_frame(2043, 0, 1, 0, 2, 0);  // R2 count 2048 with CRC stripped
      run_frame(2044, 0, 1, 0, 3, 0);  // R7 count 2050 rejected
      run_frame(100,  1, 0, 0, 0, 0);  // R7 receive disabled
      run_frame(100,  1, 1, 1, 1, 0);  // R7 soft reset
      run_frame(70,   1, 1, 0, 1, 1);  // R9 start while busy
      run_frame(0,    1, 1, 0, 2, 0);  // R4 empty frame fully padded

      // Constrained random frames.
      for (int n = 0; n < 12; n++) begin
         run_frame(1 + int'($urandom % 300), bit'($urandom % 2), 1, 0, int'($urandom % 4), 0);
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule